// File: doc/BRIEF.md
# Programmable Loop Divider with Prescaled, Direct and Low-Band Modes

This block sits in the feedback path of a frequency synthesizer loop. It counts cycles of a local-oscillator signal and emits one pulse for every N cycles it accepts. That pulse stream goes to a phase comparator. The oscillator signals are modelled as one-cycle-wide pulses that are sampled on a common system clock. Two mode bits choose among three arrangements of the same 16-bit divisor word:

- A high-band path passes through a divide-by-two stage.
- A direct path uses the whole word.
- A low-band path reads only the upper twelve bits of the word.

Values below a mode's legal floor are raised to that floor. A new divisor is picked up only when a division cycle starts, so a change never shortens or stretches the cycle that is already running. While the inhibit input is high, the whole counting chain is frozen.

Top module: `lodiv_top`

## Requirements
- R1: With `band_sel`=1, `div_out` pulses once per 2·N accepted `hb_pulse` events, where N is `div_word` clamped to at least 272. `lb_pulse` has no effect in this mode.
- R2: With `band_sel`=0 and `swallow_en`=1, `div_out` pulses once per N accepted `lb_pulse` events, where N is `div_word` clamped to at least 272. `hb_pulse` has no effect in this mode.
- R3: With `band_sel`=0 and `swallow_en`=0, N is taken from `div_word[15:4]`, and bits 3..0 have no effect on the output timing.
- R4: In the two 16-bit modes, any word below 272 divides by exactly 272.
- R5: In the low-band mode, a 12-bit field below 4 divides by exactly 4, and N never exceeds 4095.
- R6: While `inhibit` is 1, input pulses are not counted and `div_out` stays 0. Counting resumes from the held position once `inhibit` returns to 0.
- R7: The divisor is sampled on the first accepted input event of each division cycle. A change to the word part-way through a cycle applies only from the next cycle.
- R8: `div_out` is high for exactly one clock, in the clock after the input event that completes a cycle. It is never high in two consecutive clocks.
- R9: While `rst_n` is low, `div_out` is 0. After release, the first cycle counts from the first accepted event.
- R10: In prescaled mode, a word of 0x07DE (2014) gives exactly 4028 `hb_pulse` events between successive output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which the oscillator pulses are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_pulse | input | 1 | High-band oscillator event, one clock wide |
| lb_pulse | input | 1 | Low-band oscillator event, one clock wide |
| div_word | input | 16 | Programmed divisor word |
| band_sel | input | 1 | 1 selects the prescaled high-band path |
| swallow_en | input | 1 | With band_sel=0: 1 selects the 16-bit direct path, 0 selects the 12-bit low-band path |
| inhibit | input | 1 | Freezes all counting while high |
| div_out | output | 1 | Divided output pulse |

## Verification
The assertions assume that the mode bits change only while reset is held. A mode switch part-way through a cycle could leave a count above the low-band limit. The stimulus therefore applies a reset before every new mode. It also assumes that the pulse inputs are already synchronous to the system clock and one clock wide, which the bench provides by driving them on the falling edge.

Divisor rewrites mid-cycle are issued only in the two direct-input modes. In prescaled mode the sampling point falls on the second raw event of a cycle, so the bench keeps the word fixed for a whole prescaled run.

// File: rtl/lodiv_pkg.sv
`timescale 1ns/1ps
package lodiv_pkg;

  typedef enum logic [1:0] {
    MODE_LOW    = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_PRESC  = 2'b10
  } lodiv_mode_e;

  function automatic lodiv_mode_e decode_mode(input logic band_sel, input logic swallow_en);
    if (band_sel)        return MODE_PRESC;
    else if (swallow_en) return MODE_DIRECT;
    else                 return MODE_LOW;
  endfunction

  function automatic logic [31:0] raise_to(input logic [31:0] v, input logic [31:0] floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

endpackage

// File: rtl/lodiv_prescaler.sv
`timescale 1ns/1ps
module lodiv_prescaler (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  output logic ev_out
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= 1'b0;
    else if (ev_in) phase_q <= ~phase_q;
  end

  // every second accepted event passes on
  assign ev_out = ev_in & phase_q;
endmodule

// File: rtl/lodiv_ratio.sv
`timescale 1ns/1ps
module lodiv_ratio
  import lodiv_pkg::*;
#(
  parameter int W         = 16,
  parameter int LOW_SHIFT = 4,
  parameter int SW_MIN    = 272,
  parameter int LOW_MIN   = 4
) (
  input  lodiv_mode_e  mode,
  input  logic [W-1:0] word,
  output logic [W-1:0] ratio
);
  localparam int LOW_W = W - LOW_SHIFT;

  logic [31:0] full_v;
  logic [31:0] low_v;

  always_comb begin
    full_v = raise_to(32'(word), 32'(SW_MIN));
    low_v  = raise_to(32'(word[W-1:LOW_SHIFT]), 32'(LOW_MIN));
    if (mode == MODE_LOW) ratio = W'(low_v[LOW_W-1:0]);
    else                  ratio = full_v[W-1:0];
  end
endmodule

// File: rtl/lodiv_counter.sv
`timescale 1ns/1ps
module lodiv_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic [W-1:0] cnt,
  output logic         pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          cnt <= ratio - W'(1);
        end else if (cnt == W'(1)) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lodiv_top.sv
`timescale 1ns/1ps
module lodiv_top
  import lodiv_pkg::*;
#(
  parameter int W         = 16,
  parameter int LOW_SHIFT = 4,
  parameter int SW_MIN    = 272,
  parameter int LOW_MIN   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hb_pulse,
  input  logic         lb_pulse,
  input  logic [W-1:0] div_word,
  input  logic         band_sel,
  input  logic         swallow_en,
  input  logic         inhibit,
  output logic         div_out
);
  lodiv_mode_e  mode;
  logic         presc_in;
  logic         presc_ev;
  logic         tick;
  logic [W-1:0] ratio;
  logic [W-1:0] cnt;

  assign mode     = decode_mode(band_sel, swallow_en);
  assign presc_in = hb_pulse & ~inhibit & (mode == MODE_PRESC);

  lodiv_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .ev_in(presc_in), .ev_out(presc_ev)
  );

  assign tick = (mode == MODE_PRESC) ? presc_ev : (lb_pulse & ~inhibit);

  lodiv_ratio #(.W(W), .LOW_SHIFT(LOW_SHIFT), .SW_MIN(SW_MIN), .LOW_MIN(LOW_MIN)) u_ratio (
    .mode(mode), .word(div_word), .ratio(ratio)
  );

  lodiv_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ratio(ratio), .cnt(cnt), .pulse(div_out)
  );
endmodule

// File: rtl/lodiv_chk.sv
`timescale 1ns/1ps
module lodiv_chk
  import lodiv_pkg::*;
#(
  parameter int W         = 16,
  parameter int LOW_SHIFT = 4,
  parameter int SW_MIN    = 272,
  parameter int LOW_MIN   = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inhibit,
  input lodiv_mode_e  mode,
  input logic         tick,
  input logic [W-1:0] ratio,
  input logic [W-1:0] cnt,
  input logic         div_out
);
  localparam int LOW_MAX = (1 << (W - LOW_SHIFT)) - 1;

  assert_one_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  assert_from_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> $past(tick));

  assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !div_out);

  assert_inhibit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> $stable(cnt));

  assert_swallow_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_LOW) |-> (32'(ratio) >= SW_MIN));

  assert_low_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOW) |-> (32'(ratio) >= LOW_MIN && 32'(ratio) <= LOW_MAX && 32'(cnt) < LOW_MAX));

  assert_cycle_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0) |=> (cnt == $past(ratio) - W'(1)));
endmodule

bind lodiv_top lodiv_chk #(.W(W), .LOW_SHIFT(LOW_SHIFT), .SW_MIN(SW_MIN), .LOW_MIN(LOW_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .mode(mode), .tick(tick),
  .ratio(ratio), .cnt(cnt), .div_out(div_out)
);

// File: tb/tb_lodiv_top.sv
`timescale 1ns/1ps
module tb_lodiv_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_pulse = 1'b0;
  logic        lb_pulse = 1'b0;
  logic [15:0] div_word = 16'd0;
  logic        band_sel = 1'b0;
  logic        swallow_en = 1'b0;
  logic        inhibit = 1'b0;
  logic        div_out;

  int checks = 0;
  int errors = 0;
  int raw = 0;          // accepted source events in current cycle
  int cyc_len = 1;      // raw events per cycle, captured at cycle start
  int outs = 0;         // expected output pulses so far
  int acc_total = 0;    // accepted events since reset
  int last_out_at = 0;
  int gap = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lodiv_top dut (
    .clk(clk), .rst_n(rst_n), .hb_pulse(hb_pulse), .lb_pulse(lb_pulse),
    .div_word(div_word), .band_sel(band_sel), .swallow_en(swallow_en),
    .inhibit(inhibit), .div_out(div_out)
  );

  // raw source events per output, derived from the requirements
  function automatic int events_per_out(bit b, bit s, logic [15:0] w);
    int n;
    if (b || s) begin
      n = (w < 16'd272) ? 272 : int'(w);
      return b ? 2 * n : n;
    end
    n = int'(w) / 16;
    return (n < 4) ? 4 : n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(bit b, bit s, logic [15:0] w);
    rst_n = 1'b0; hb_pulse = 1'b0; lb_pulse = 1'b0; inhibit = 1'b0;
    band_sel = b; swallow_en = s; div_word = w;
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R9 reset output", int'(div_out), 0);
    rst_n = 1'b1;
    raw = 0; outs = 0; acc_total = 0; last_out_at = 0; gap = 0;
  endtask

  // called at a falling edge; drives one clock of stimulus and checks it
  task automatic step(bit h, bit l, bit inh, string req);
    bit src, exp;
    hb_pulse = h; lb_pulse = l; inhibit = inh;
    src = band_sel ? h : l;
    exp = 1'b0;
    if (src && !inh) begin
      if (raw == 0) cyc_len = events_per_out(band_sel, swallow_en, div_word);
      raw++;
      acc_total++;
      if (raw == cyc_len) begin
        exp = 1'b1;
        raw = 0;
        outs++;
        gap = acc_total - last_out_at;
        last_out_at = acc_total;
      end
    end
    @(negedge clk);
    check(div_out == exp, req, int'(div_out), int'(exp));
  endtask

  // run until a given number of outputs, with a random pulse density
  task automatic run_outs(int want, int dens, int inh_pct, bit rewrite, string req);
    int guard = 0;
    while (outs < want && guard < 9000) begin
      bit h, l, i;
      h = ($urandom % 100) < dens;
      l = ($urandom % 100) < dens;
      i = ($urandom % 100) < inh_pct;
      if (rewrite && !band_sel && ($urandom % 100) < 2)
        div_word = swallow_en ? 16'(200 + $urandom % 200) : 16'(($urandom % 40) << 4 | $urandom % 16);
      step(h, l, i, req);
      guard++;
    end
  endtask

  initial begin
    void'($urandom(32'd1957));
    @(negedge clk);

    // R10: prescaled example, one event every clock
    do_reset(1'b1, 1'b0, 16'h07DE);
    while (outs < 2) step(1'b1, $urandom % 2, 1'b0, "R10 prescaled 2014");
    check(gap == 4028, "R10 events between outputs", gap, 4028);

    // R4: floor in direct mode
    do_reset(1'b0, 1'b1, 16'd5);
    while (outs < 2) step($urandom % 2, 1'b1, 1'b0, "R4 floor 272");
    check(gap == 272, "R4 gap", gap, 272);

    // R4: floor in prescaled mode
    do_reset(1'b1, 1'b1, 16'd100);
    while (outs < 1) step(1'b1, 1'b0, 1'b0, "R4 prescaled floor");
    check(gap == 544, "R4 prescaled gap", gap, 544);

    // R5: low-band floor, field 3
    do_reset(1'b0, 1'b0, 16'h0032);
    while (outs < 3) step(1'b0, 1'b1, 1'b0, "R5 floor 4");
    check(gap == 4, "R5 gap", gap, 4);

    // R3: low nibble ignored
    do_reset(1'b0, 1'b0, 16'h0A7F);
    while (outs < 2) step($urandom % 2, 1'b1, 1'b0, "R3 nibble ignored");
    check(gap == 167, "R3 gap", gap, 167);

    // R7: mid-cycle rewrite applies from next cycle
    do_reset(1'b0, 1'b1, 16'd300);
    for (int k = 0; k < 100; k++) step(1'b0, 1'b1, 1'b0, "R7 before rewrite");
    div_word = 16'd280;
    while (outs < 1) step(1'b0, 1'b1, 1'b0, "R7 old ratio");
    check(gap == 300, "R7 first cycle keeps old", gap, 300);
    while (outs < 2) step(1'b0, 1'b1, 1'b0, "R7 new ratio");
    check(gap == 280, "R7 second cycle new", gap, 280);

    // R6: long inhibit with pulses on both inputs
    do_reset(1'b0, 1'b1, 16'd272);
    for (int k = 0; k < 150; k++) step(1'b0, 1'b1, 1'b0, "R6 pre");
    for (int k = 0; k < 400; k++) step(1'b1, 1'b1, 1'b1, "R6 inhibited");
    while (outs < 1) step(1'b0, 1'b1, 1'b0, "R6 resume");
    check(gap == 272, "R6 count held across inhibit", gap, 272);

    // random rounds over all modes (R1 R2 R3 R8)
    for (int r = 0; r < 12; r++) begin
      bit b, s;
      logic [15:0] w;
      b = $urandom % 2;
      s = $urandom % 2;
      if (b || s) w = 16'(200 + $urandom % 220);
      else        w = 16'(($urandom % 60) << 4 | $urandom % 16);
      do_reset(b, s, w);
      if (b)      run_outs(3, 60 + $urandom % 40, 8, 1'b0, "R1 prescaled random");
      else if (s) run_outs(3, 50 + $urandom % 50, 8, 1'b1, "R2 direct random");
      else        run_outs(4, 50 + $urandom % 50, 8, 1'b1, "R3 low-band random");
      check(outs >= 3, "R8 outputs produced", outs, 3);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule